// File: doc/BRIEF.md
# Interrupt Presenter Register Window

This block presents interrupts to a group of hardware threads. Each thread owns one 4 KB register window inside a 1 MB region. The window is picked by the thread's processor number, carried in the address bits just above the window offset. Every thread keeps five pieces of state: a current priority (CPPR), a pending source number and its priority, an inter-processor request priority (MFRR), and three general link words. Every thread also drives its own interrupt line. Software talks to the block with single loads and stores of one byte or one word. A single offset behaves differently depending on the access width and direction:

- A word read of the accept register claims the pending interrupt, while a byte read of that register only peeks at the priority.
- A byte write sets the priority, while a word write ends the interrupt.

Requests arrive on a valid/ready port. Each accepted request produces exactly one registered response one cycle later. The response is held until the consumer raises `rsp_ready`, and `bus_ready` stays low while a response is held. This means a stalled consumer stalls the bus, and nothing is ever dropped.

External interrupts stand in for a source controller. They arrive on a second valid/ready port that carries a target thread, a source number and a priority. `src_ready` is a combinational function of the offered thread and priority, and of the target thread's state. A source that is not taken must stay offered until it is taken; the block never drops it.

Top module: `intr_presenter`

## Requirements
- R1: After reset, every thread has CPPR 0x00, MFRR 0xFF, no pending source and all link words zero, and its interrupt line is low; no response is pending and `bus_ready` is high.
- R2: The thread index is `bus_addr[12 +: THREAD_W]`, and the register is chosen by `bus_addr[11:2]`. An index at or beyond `NUM_THREADS` is an undefined window, and each thread's state is reached only through its own window.
- R3: The value XIRR is `{CPPR[7:0], XISR[23:0]}`. XISR is the pending source number when that source is presented, and zero otherwise. A word read at offset 0 returns XIRR without changing any state. A byte read at byte 0 of offset 0 or of offset 4 returns CPPR in `rsp_rdata[7:0]` with the upper bits zero, and also changes nothing.
- R4: A word read at offset 4 returns XIRR. If an interrupt is presented, CPPR takes the pending priority, the pending source is cleared and the interrupt line drops on the following cycle.
- R5: A byte write at offset 4 loads CPPR from `bus_wdata[7:0]`. A word write at offset 4 is end-of-interrupt and loads CPPR from `bus_wdata[31:24]`.
- R6: MFRR sits at offset 12 and is read and written only as a byte at byte 0, using data bits [7:0]. While MFRR is not 0xFF and is numerically below CPPR, and nothing is pending, an inter-processor request becomes pending with source number 2 and priority MFRR. Writing 0xFF to MFRR withdraws a pending inter-processor request.
- R7: Offsets 16, 20 and 24 hold three independent 32-bit link words, read and written only as aligned words, with no side effect.
- R8: An access is illegal in any of these cases: an undefined offset, a width the offset does not allow, a byte access with `bus_addr[1:0]` not zero, a word access that is not aligned, or any write at offset 0. An illegal access sets `rsp_err`. An illegal read returns 0xFFFFFFFF, and an illegal write leaves all state unchanged. Write responses carry data 0.
- R9: A source is presented only when its priority is numerically strictly below CPPR. An offered source is taken (`src_ready` high) only when all of these hold: the target thread exists, nothing is pending on it, no inter-processor request is due, its priority is below CPPR, and the bus is not accessing that thread in the same cycle. A taken source raises the interrupt line on the next cycle. A pending source that is masked by a CPPR change stays held with its line low, and it returns when CPPR is lowered again.
- R10: When an inter-processor request and an external source both qualify on an idle thread, the inter-processor request is taken first.
- R11: Each accepted request yields one response on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response data and error flag hold steady and `bus_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request valid |
| bus_ready | output | 1 | Register request can be taken |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_word | input | 1 | 1 = 4-byte access, 0 = 1-byte access |
| bus_addr | input | 12+THREAD_W | Byte address inside the per-chip region |
| bus_wdata | input | 32 | Store data (byte stores use bits [7:0]) |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_rdata | output | 32 | Load data (byte loads in bits [7:0]) |
| rsp_err | output | 1 | Request was illegal |
| src_valid | input | 1 | External source offered |
| src_ready | output | 1 | Offered source taken this cycle |
| src_thread | input | THREAD_W | Target thread of the offered source |
| src_id | input | 24 | Source number, at least 3 |
| src_prio | input | 8 | Source priority, lower is more favoured |
| irq_o | output | NUM_THREADS | Per-thread interrupt line |

## Verification
The bench builds the block with `NUM_THREADS` = 2 and the full 8-bit thread index. Thread 1 is therefore available to show that windows are isolated from one another. Index 2 and above reach the undefined-window path with a plain address, without a large instance. With two threads, the bench can also hold an external source offered to one thread while that same thread's MFRR is being written. This brings the tie between the bus access and the source, and the precedence of inter-processor requests, within a few cycles.

// File: rtl/ipres_pkg.sv
package ipres_pkg;
  localparam int WIN_BITS  = 12;
  localparam int NUM_LINKS = 3;
  localparam int LSEL_W    = 2;
  localparam logic [23:0] IPI_SRC   = 24'd2;
  localparam logic [7:0]  PRIO_NONE = 8'hFF;

  typedef enum logic [3:0] {
    OP_POLL,      // word read of XIRR, no side effect
    OP_PEEK,      // byte read of CPPR
    OP_ACCEPT,    // word read at accept register
    OP_SET_CPPR,  // byte write at accept register
    OP_EOI,       // word write at accept register
    OP_RD_MFRR,
    OP_WR_MFRR,
    OP_RD_LINK,
    OP_WR_LINK,
    OP_BAD
  } op_e;
endpackage

// File: rtl/ipres_decode.sv
module ipres_decode
  import ipres_pkg::*;
#(
  parameter int THREAD_W    = 8,
  parameter int NUM_THREADS = 4
) (
  input  logic                         write,
  input  logic                         word,
  input  logic [WIN_BITS+THREAD_W-1:0] addr,
  output op_e                          op,
  output logic [LSEL_W-1:0]            link_sel,
  output logic [THREAD_W-1:0]          tid
);
  localparam logic [THREAD_W:0] NT = NUM_THREADS[THREAD_W:0];

  logic [9:0] offset;
  logic       byte0, word_ok, tid_ok;

  assign tid     = addr[WIN_BITS +: THREAD_W];
  assign tid_ok  = {1'b0, tid} < NT;
  assign offset  = addr[11:2];
  assign byte0   = !word && (addr[1:0] == 2'b00);
  assign word_ok = word && (addr[1:0] == 2'b00);

  always_comb begin
    op       = OP_BAD;
    link_sel = offset[LSEL_W-1:0];
    if (tid_ok) begin
      case (offset)
        10'd0: begin
          if (!write && word_ok)    op = OP_POLL;
          else if (!write && byte0) op = OP_PEEK;
        end
        10'd1: begin
          if (!write) begin
            if (word_ok)    op = OP_ACCEPT;
            else if (byte0) op = OP_PEEK;
          end else begin
            if (word_ok)    op = OP_EOI;
            else if (byte0) op = OP_SET_CPPR;
          end
        end
        10'd3: begin
          if (byte0) op = write ? OP_WR_MFRR : OP_RD_MFRR;
        end
        10'd4, 10'd5, 10'd6: begin
          if (word_ok) op = write ? OP_WR_LINK : OP_RD_LINK;
        end
        default: op = OP_BAD;
      endcase
    end
  end
endmodule

// File: rtl/ipres_thread.sv
module ipres_thread
  import ipres_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            op_en,
  input  op_e                             op,
  input  logic [LSEL_W-1:0]               link_sel,
  input  logic [31:0]                     wdata,
  input  logic                            src_take,
  input  logic [23:0]                     src_id,
  input  logic [7:0]                      src_prio,
  output logic [31:0]                     xirr,
  output logic [7:0]                      mfrr_o,
  output logic [NUM_LINKS-1:0][31:0]      links_o,
  output logic                            irq,
  output logic                            can_take
);
  logic [7:0]  cppr, pprio, mfrr;
  logic [23:0] xisr;
  logic        presented, ipi_due;

  assign presented = (xisr != 24'd0) && (pprio < cppr);
  assign ipi_due   = (mfrr != PRIO_NONE) && (mfrr < cppr);
  assign can_take  = (xisr == 24'd0) && !ipi_due && (src_prio < cppr) && !op_en;
  assign xirr      = {cppr, presented ? xisr : 24'd0};
  assign irq       = presented;
  assign mfrr_o    = mfrr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr  <= 8'h00;
      pprio <= PRIO_NONE;
      mfrr  <= PRIO_NONE;
      xisr  <= 24'd0;
    end else if (op_en) begin
      case (op)
        OP_ACCEPT: begin
          if (presented) begin
            cppr <= pprio;
            xisr <= 24'd0;
          end
        end
        OP_SET_CPPR: cppr <= wdata[7:0];
        OP_EOI:      cppr <= wdata[31:24];
        OP_WR_MFRR: begin
          mfrr <= wdata[7:0];
          if (xisr == IPI_SRC) begin
            if (wdata[7:0] == PRIO_NONE) xisr <= 24'd0;
            else                         pprio <= wdata[7:0];
          end
        end
        default: ;
      endcase
    end else if (xisr == 24'd0) begin
      if (ipi_due) begin
        xisr  <= IPI_SRC;
        pprio <= mfrr;
      end else if (src_take) begin
        xisr  <= src_id;
        pprio <= src_prio;
      end
    end
  end

  for (genvar k = 0; k < NUM_LINKS; k++) begin : g_link
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        links_o[k] <= 32'd0;
      else if (op_en && op == OP_WR_LINK && link_sel == LSEL_W'(k))
        links_o[k] <= wdata;
    end
  end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter
  import ipres_pkg::*;
#(
  parameter int THREAD_W    = 8,
  parameter int NUM_THREADS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_valid,
  output logic                         bus_ready,
  input  logic                         bus_write,
  input  logic                         bus_word,
  input  logic [WIN_BITS+THREAD_W-1:0] bus_addr,
  input  logic [31:0]                  bus_wdata,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic [31:0]                  rsp_rdata,
  output logic                         rsp_err,
  input  logic                         src_valid,
  output logic                         src_ready,
  input  logic [THREAD_W-1:0]          src_thread,
  input  logic [23:0]                  src_id,
  input  logic [7:0]                   src_prio,
  output logic [NUM_THREADS-1:0]       irq_o
);
  logic                fire;
  op_e                 dec_op;
  logic [LSEL_W-1:0]   dec_lsel;
  logic [THREAD_W-1:0] dec_tid;

  logic [31:0]                xirr_a  [NUM_THREADS];
  logic [7:0]                 mfrr_a  [NUM_THREADS];
  logic [NUM_LINKS-1:0][31:0] links_a [NUM_THREADS];
  logic [NUM_THREADS-1:0]     op_en, can_take, src_take;

  logic [31:0] sel_xirr, sel_link, rdata_next;
  logic [7:0]  sel_mfrr;

  assign bus_ready = !rsp_valid || rsp_ready;
  assign fire      = bus_valid && bus_ready;

  ipres_decode #(.THREAD_W(THREAD_W), .NUM_THREADS(NUM_THREADS)) u_dec (
    .write    (bus_write),
    .word     (bus_word),
    .addr     (bus_addr),
    .op       (dec_op),
    .link_sel (dec_lsel),
    .tid      (dec_tid)
  );

  for (genvar i = 0; i < NUM_THREADS; i++) begin : g_thr
    assign op_en[i]    = fire && (dec_op != OP_BAD) && (dec_tid == THREAD_W'(i));
    assign src_take[i] = src_valid && can_take[i] && (src_thread == THREAD_W'(i));

    ipres_thread u_thr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_en    (op_en[i]),
      .op       (dec_op),
      .link_sel (dec_lsel),
      .wdata    (bus_wdata),
      .src_take (src_take[i]),
      .src_id   (src_id),
      .src_prio (src_prio),
      .xirr     (xirr_a[i]),
      .mfrr_o   (mfrr_a[i]),
      .links_o  (links_a[i]),
      .irq      (irq_o[i]),
      .can_take (can_take[i])
    );
  end

  always_comb begin
    src_ready = 1'b0;
    for (int i = 0; i < NUM_THREADS; i++)
      if (src_thread == THREAD_W'(i)) src_ready = can_take[i];
  end

  always_comb begin
    sel_xirr = 32'd0;
    sel_mfrr = 8'd0;
    sel_link = 32'd0;
    for (int i = 0; i < NUM_THREADS; i++) begin
      if (dec_tid == THREAD_W'(i)) begin
        sel_xirr = xirr_a[i];
        sel_mfrr = mfrr_a[i];
        for (int k = 0; k < NUM_LINKS; k++)
          if (dec_lsel == LSEL_W'(k)) sel_link = links_a[i][k];
      end
    end
  end

  always_comb begin
    case (dec_op)
      OP_POLL, OP_ACCEPT: rdata_next = sel_xirr;
      OP_PEEK:            rdata_next = {24'd0, sel_xirr[31:24]};
      OP_RD_MFRR:         rdata_next = {24'd0, sel_mfrr};
      OP_RD_LINK:         rdata_next = sel_link;
      OP_BAD:             rdata_next = bus_write ? 32'd0 : 32'hFFFF_FFFF;
      default:            rdata_next = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 32'd0;
      rsp_err   <= 1'b0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rdata_next;
      rsp_err   <= (dec_op == OP_BAD);
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ipres_checker.sv
module ipres_checker #(
  parameter int THREAD_W    = 8,
  parameter int NUM_THREADS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_valid,
  input logic                   bus_ready,
  input logic                   bus_write,
  input logic                   bus_word,
  input logic [12+THREAD_W-1:0] bus_addr,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [31:0]            rsp_rdata,
  input logic                   rsp_err,
  input logic                   src_valid,
  input logic                   src_ready,
  input logic [THREAD_W-1:0]    src_thread,
  input logic [NUM_THREADS-1:0] irq_o
);
  logic                   fire, bad_rd;
  logic [NUM_THREADS-1:0] take_vec, acc_vec;

  assign fire   = bus_valid && bus_ready;
  assign bad_rd = fire && !bus_write && bus_word && (bus_addr[11:0] == 12'h008);

  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) begin
      take_vec[i] = src_valid && src_ready && (src_thread == THREAD_W'(i));
      acc_vec[i]  = fire && !bus_write && bus_word && (bus_addr[11:0] == 12'h004)
                    && (bus_addr[12 +: THREAD_W] == THREAD_W'(i)) && irq_o[i];
    end
  end

  assert_hold_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_err));

  assert_stall_bus_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !bus_ready);

  assert_take_raises_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|take_vec) |=> ((irq_o & $past(take_vec)) == $past(take_vec)));

  assert_accept_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|acc_vec) |=> ((irq_o & $past(acc_vec)) == '0));

  assert_bad_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rd |=> rsp_valid && rsp_err && (rsp_rdata == 32'hFFFF_FFFF));
endmodule

bind intr_presenter ipres_checker #(.THREAD_W(THREAD_W), .NUM_THREADS(NUM_THREADS)) u_ipres_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_valid  (bus_valid),
  .bus_ready  (bus_ready),
  .bus_write  (bus_write),
  .bus_word   (bus_word),
  .bus_addr   (bus_addr),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .rsp_err    (rsp_err),
  .src_valid  (src_valid),
  .src_ready  (src_ready),
  .src_thread (src_thread),
  .irq_o      (irq_o)
);

// File: tb/test_intr_presenter.sv
`timescale 1ns/1ps
module test_intr_presenter;
  localparam int THREAD_W = 8;
  localparam int NTHR     = 2;
  localparam int AW       = 12 + THREAD_W;

  typedef struct packed {
    logic          wr;
    logic          word;
    logic [AW-1:0] addr;
    logic [31:0]   wd;
    logic [31:0]   exp;
    logic          err;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 20'h00000, 32'h0,        32'h0000_0000, 1'b0}, // R1 XIRR after reset
    '{1'b0, 1'b0, 20'h0000C, 32'h0,        32'h0000_00FF, 1'b0}, // R1 MFRR after reset
    '{1'b0, 1'b1, 20'h00010, 32'h0,        32'h0000_0000, 1'b0}, // R1 link after reset
    '{1'b1, 1'b1, 20'h00010, 32'hA5A5_0001, 32'h0,        1'b0}, // R7
    '{1'b1, 1'b1, 20'h00014, 32'h1234_5678, 32'h0,        1'b0}, // R7
    '{1'b1, 1'b1, 20'h00018, 32'hDEAD_BEEF, 32'h0,        1'b0}, // R7
    '{1'b0, 1'b1, 20'h00010, 32'h0,        32'hA5A5_0001, 1'b0}, // R7
    '{1'b0, 1'b1, 20'h00014, 32'h0,        32'h1234_5678, 1'b0}, // R7
    '{1'b0, 1'b1, 20'h00018, 32'h0,        32'hDEAD_BEEF, 1'b0}, // R7
    '{1'b0, 1'b1, 20'h01010, 32'h0,        32'h0000_0000, 1'b0}, // R2 thread 1 isolated
    '{1'b1, 1'b0, 20'h00004, 32'h0000_00F0, 32'h0,        1'b0}, // R5 CPPR byte write
    '{1'b0, 1'b0, 20'h00000, 32'h0,        32'h0000_00F0, 1'b0}, // R3 byte poll
    '{1'b0, 1'b1, 20'h00000, 32'h0,        32'hF000_0000, 1'b0}, // R3 word poll
    '{1'b0, 1'b0, 20'h00004, 32'h0,        32'h0000_00F0, 1'b0}, // R3 byte peek at 4
    '{1'b1, 1'b0, 20'h0000C, 32'h0000_0040, 32'h0,        1'b0}, // R6 MFRR write
    '{1'b0, 1'b1, 20'h00000, 32'h0,        32'hF000_0002, 1'b0}, // R6 IPI presented
    '{1'b0, 1'b0, 20'h0000C, 32'h0,        32'h0000_0040, 1'b0}, // R6 MFRR read
    '{1'b0, 1'b1, 20'h00004, 32'h0,        32'hF000_0002, 1'b0}, // R4 accept
    '{1'b0, 1'b1, 20'h00000, 32'h0,        32'h4000_0000, 1'b0}, // R4 after accept
    '{1'b1, 1'b1, 20'h00004, 32'hFF00_0000, 32'h0,        1'b0}, // R5 EOI
    '{1'b0, 1'b1, 20'h00000, 32'h0,        32'hFF00_0002, 1'b0}, // R6 IPI again
    '{1'b1, 1'b0, 20'h0000C, 32'h0000_00FF, 32'h0,        1'b0}, // R6 withdraw
    '{1'b0, 1'b1, 20'h00000, 32'h0,        32'hFF00_0000, 1'b0}, // R6 withdrawn
    '{1'b0, 1'b1, 20'h00008, 32'h0,        32'hFFFF_FFFF, 1'b1}, // R8 undefined offset
    '{1'b0, 1'b0, 20'h00001, 32'h0,        32'hFFFF_FFFF, 1'b1}, // R8 byte not 0
    '{1'b0, 1'b1, 20'h0000C, 32'h0,        32'hFFFF_FFFF, 1'b1}, // R8 MFRR as word
    '{1'b1, 1'b0, 20'h00010, 32'h0000_0011, 32'h0,        1'b1}, // R8 link as byte
    '{1'b0, 1'b1, 20'h00010, 32'h0,        32'hA5A5_0001, 1'b0}, // R8 link untouched
    '{1'b1, 1'b1, 20'h00000, 32'h0000_0001, 32'h0,        1'b1}, // R8 write to poll
    '{1'b0, 1'b1, 20'h02000, 32'h0,        32'hFFFF_FFFF, 1'b1}, // R2 thread out of range
    '{1'b1, 1'b0, 20'h02004, 32'h0000_0010, 32'h0,        1'b1}, // R2 write out of range
    '{1'b0, 1'b0, 20'h01000, 32'h0,        32'h0000_0000, 1'b0}, // R2 thread 1 CPPR intact
    '{1'b0, 1'b1, 20'h0001C, 32'h0,        32'hFFFF_FFFF, 1'b1}, // R8 past last link
    '{1'b1, 1'b0, 20'h00005, 32'h0000_0010, 32'h0,        1'b1}, // R8 byte 1 write
    '{1'b0, 1'b1, 20'h00002, 32'h0,        32'hFFFF_FFFF, 1'b1}, // R8 misaligned word
    '{1'b0, 1'b1, 20'h00000, 32'h0,        32'hFF00_0000, 1'b0}  // R8 CPPR unchanged
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_valid = 1'b0, bus_write = 1'b0, bus_word = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic            bus_ready, rsp_valid, rsp_err, src_ready;
  logic            rsp_ready = 1'b1;
  logic [31:0]     rsp_rdata;
  logic            src_valid = 1'b0;
  logic [THREAD_W-1:0] src_thread = '0;
  logic [23:0]     src_id = '0;
  logic [7:0]      src_prio = '0;
  logic [NTHR-1:0] irq_o;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  intr_presenter #(.THREAD_W(THREAD_W), .NUM_THREADS(NTHR)) i_intr_presenter (
    .clk(clk), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
    .bus_word(bus_word), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .src_valid(src_valid), .src_ready(src_ready),
    .src_thread(src_thread), .src_id(src_id), .src_prio(src_prio), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic wd, input logic [AW-1:0] a,
                      input logic [31:0] d, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_word = wd; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    chk("R11 response present", {31'd0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
    er = rsp_err;
  endtask

  task automatic expect_rd(input string req, input logic wd, input logic [AW-1:0] a,
                           input logic [31:0] exp);
    logic [31:0] rd; logic er;
    xfer(1'b0, wd, a, 32'd0, rd, er);
    chk(req, rd, exp);
    chk(req, {31'd0, er}, 32'd0);
  endtask

  task automatic do_wr(input logic wd, input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    xfer(1'b1, wd, a, d, rd, er);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic er;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1 irq low in reset", {30'd0, irq_o}, 32'd0);
    chk("R1 no response in reset", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus_ready after reset", {31'd0, bus_ready}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      xfer(VECS[v].wr, VECS[v].word, VECS[v].addr, VECS[v].wd, rd, er);
      chk($sformatf("vector %0d data", v), rd, VECS[v].exp);
      chk($sformatf("vector %0d err", v), {31'd0, er}, {31'd0, VECS[v].err});
    end

    // R9: external source on thread 0 (CPPR 0xFF)
    @(negedge clk);
    src_valid = 1'b1; src_thread = 8'd0; src_id = 24'h000123; src_prio = 8'h30;
    #1 chk("R9 source taken", {31'd0, src_ready}, 32'd1);
    @(negedge clk);
    src_valid = 1'b0;
    chk("R9 irq raised", {30'd0, irq_o}, 32'd1);
    expect_rd("R9 poll shows source", 1'b1, 20'h00000, 32'hFF00_0123);
    do_wr(1'b0, 20'h00004, 32'h0000_0020);
    @(negedge clk);
    chk("R9 masked irq low", {30'd0, irq_o}, 32'd0);
    expect_rd("R9 masked XISR reads 0", 1'b1, 20'h00000, 32'h2000_0000);
    src_valid = 1'b1; src_prio = 8'h10; src_id = 24'h000456;
    #1 chk("R9 busy thread refuses", {31'd0, src_ready}, 32'd0);
    src_valid = 1'b0;
    do_wr(1'b0, 20'h00004, 32'h0000_00FF);
    @(negedge clk);
    chk("R9 unmasked irq back", {30'd0, irq_o}, 32'd1);
    expect_rd("R4 accept source", 1'b1, 20'h00004, 32'hFF00_0123);
    chk("R4 irq dropped", {30'd0, irq_o}, 32'd0);
    expect_rd("R4 CPPR took priority", 1'b1, 20'h00000, 32'h3000_0000);
    src_valid = 1'b1; src_prio = 8'h30; src_thread = 8'd0;
    #1 chk("R9 equal priority refused", {31'd0, src_ready}, 32'd0);
    src_thread = 8'd2; src_prio = 8'h00;
    #1 chk("R9 absent thread refused", {31'd0, src_ready}, 32'd0);
    src_valid = 1'b0;

    // R10: IPI wins over external on thread 1
    do_wr(1'b1, 20'h01004, 32'hFF00_0000);
    @(negedge clk);
    src_valid = 1'b1; src_thread = 8'd1; src_id = 24'h000777; src_prio = 8'h50;
    bus_valid = 1'b1; bus_write = 1'b1; bus_word = 1'b0; bus_addr = 20'h0100C;
    bus_wdata = 32'h0000_0060;
    #1 chk("R9 refused during bus access", {31'd0, src_ready}, 32'd0);
    @(negedge clk);
    bus_valid = 1'b0;
    #1 chk("R10 IPI due blocks source", {31'd0, src_ready}, 32'd0);
    @(negedge clk);
    chk("R10 IPI presented", {30'd0, irq_o}, 32'd2);
    src_valid = 1'b0;
    expect_rd("R10 XISR is IPI", 1'b1, 20'h01000, 32'hFF00_0002);

    // R11: response back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    bus_valid = 1'b1; bus_write = 1'b0; bus_word = 1'b1; bus_addr = 20'h00014;
    @(negedge clk);
    bus_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11 response held", {31'd0, rsp_valid}, 32'd1);
    chk("R11 bus stalled", {31'd0, bus_ready}, 32'd0);
    chk("R11 data stable", rsp_rdata, 32'h1234_5678);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R11 response consumed", {31'd0, rsp_valid}, 32'd0);

    // R1: reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 irq cleared by reset", {30'd0, irq_o}, 32'd0);
    rst_n = 1'b1;
    expect_rd("R1 link cleared", 1'b1, 20'h00010, 32'h0);
    expect_rd("R1 MFRR reset", 1'b0, 20'h0100C, 32'h0000_00FF);
    expect_rd("R1 XIRR reset", 1'b1, 20'h01000, 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule